// File: doc/BRIEF.md
# Bracketing Auto-Baud UART Slave

This block is the receive-side rate finder of a UART slave that has no fixed baud rate. A master repeatedly sends the calibration byte 0xAA. The slave keeps its bit period as a clock-divisor count, which is the number of system clocks per bit. It first searches from the fastest setting toward slower ones until a byte decodes correctly. That divisor is the fast-side limit. It then jumps to the slowest setting and searches toward faster ones until a byte decodes correctly again. That divisor is the slow-side limit. The operating divisor is the rounded-down mean of the two limits. The slave announces lock by sending two 0x55 frames back at that divisor.

If no start bit arrives for a programmable number of bit periods during either search, the slave drops what it has learned and starts again from the fastest setting. Once locked, it holds its divisor until reset. The command handling that would follow lock is not part of this block.

Top module: `abaud_slave`

## Requirements
- R1: After reset, `cal_phase` is 0 (fast-side search), `rate_div` equals DIV_MIN, `tx` is high and `locked` is low.
- R2: In phase 0, a received 8N1 byte that is not 0xAA raises `rate_div` by STEP (one step slower), saturating at DIV_MAX.
- R3: A frame whose stop bit samples low counts as a mismatch, even when its data bits are 0xAA.
- R4: In phase 0, a correctly framed 0xAA stores the current divisor as the fast-side limit, sets `rate_div` to DIV_MAX and moves `cal_phase` to 1 (slow-side search).
- R5: In phase 1, a mismatching byte lowers `rate_div` by STEP (one step faster), saturating at DIV_MIN.
- R6: In phase 1, a correctly framed 0xAA sets `rate_div` to floor((fast-side limit + current divisor) / 2) and moves `cal_phase` to 2 (announce).
- R7: In phase 2, `tx` sends two 8N1 frames of 0x55, LSB first, each bit lasting `rate_div` clocks. After that, `cal_phase` becomes 3 and `locked` goes high.
- R8: In phase 0 or 1, if no start bit is detected for TMO_BITS × `rate_div` clocks after the last frame, the block returns to phase 0 with `rate_div` = DIV_MIN.
- R9: In phase 3, received bytes, including 0xAA, change neither `rate_div` nor `cal_phase`. Only reset leaves phase 3.
- R10: `tx` stays high in every phase other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx | input | 1 | Serial data from the master, idle high |
| tx | output | 1 | Serial data to the master, idle high |
| locked | output | 1 | High once calibration has finished |
| rate_div | output | DIV_W | Current divisor (clocks per bit); the centred value once locked |
| cal_phase | output | 2 | 0 fast-side search, 1 slow-side search, 2 announce, 3 locked |

## Verification
On every cycle, the assertions check the following:
- the saturating step taken after each mismatch in both search directions;
- the jump to DIV_MAX after the fast-side match;
- the restart after a timeout;
- that the divisor and phase do not move once locked;
- that `tx` stays idle outside the announce phase.

Some behaviours can only be shown by the bench's scenarios:
- the centring arithmetic, including the rounding down;
- the content and bit timing of the two 0x55 frames;
- the exact timeout window;
- that a bad stop bit is treated as a mismatch.

// File: rtl/abaud_pkg.sv
package abaud_pkg;
  typedef enum logic [1:0] {PH_FAST = 2'd0, PH_SLOW = 2'd1, PH_SEND = 2'd2, PH_LOCK = 2'd3} phase_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  localparam logic [7:0] CAL_BYTE = 8'hAA;
  localparam logic [7:0] ACK_BYTE = 8'h55;

  // one step toward a slower rate (larger divisor)
  function automatic int div_slower(int d, int step, int dmax);
    return (d + step > dmax) ? dmax : d + step;
  endfunction

  // one step toward a faster rate (smaller divisor)
  function automatic int div_faster(int d, int step, int dmin);
    return (d - step < dmin) ? dmin : d - step;
  endfunction

  function automatic int div_centre(int a, int b);
    return (a + b) / 2;
  endfunction

  function automatic int idle_limit(int d, int bits);
    return d * bits;
  endfunction
endpackage

// File: rtl/abaud_rx.sv
module abaud_rx
  import abaud_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  input  logic [DIV_W-1:0] div,
  output logic             done,
  output logic [7:0]       data,
  output logic             frame_ok,
  output logic             busy
);
  rx_st_t           st;
  logic             s1, s2, prev;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitn;
  logic [7:0]       shreg;
  logic [DIV_W-1:0] half;

  assign half = div >> 1;
  assign busy = (st != RX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
      st <= RX_IDLE; cnt <= '0; bitn <= '0; shreg <= '0;
      done <= 1'b0; data <= '0; frame_ok <= 1'b0;
    end else begin
      s1   <= rx;
      s2   <= s1;
      prev <= s2;
      done <= 1'b0;
      case (st)
        RX_IDLE: if (prev && !s2) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (cnt == half - 1'b1) begin
          cnt  <= '0;
          bitn <= '0;
          st   <= s2 ? RX_IDLE : RX_DATA;
        end else cnt <= cnt + 1'b1;
        RX_DATA: if (cnt == div - 1'b1) begin
          cnt   <= '0;
          shreg <= {s2, shreg[7:1]};
          bitn  <= bitn + 1'b1;
          if (bitn == 3'd7) st <= RX_STOP;
        end else cnt <= cnt + 1'b1;
        RX_STOP: if (cnt == div - 1'b1) begin
          cnt      <= '0;
          done     <= 1'b1;
          data     <= shreg;
          frame_ok <= s2;
          st       <= RX_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abaud_tx.sv
module abaud_tx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       data,
  input  logic [DIV_W-1:0] div,
  output logic             tx,
  output logic             done
);
  logic [9:0]       sreg;
  logic [3:0]       bitn;
  logic [DIV_W-1:0] cnt;
  logic             active;

  assign tx = active ? sreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '1; bitn <= '0; cnt <= '0; active <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          sreg   <= {1'b1, data, 1'b0};
          active <= 1'b1;
          cnt    <= '0;
          bitn   <= '0;
        end
      end else if (cnt == div - 1'b1) begin
        cnt  <= '0;
        sreg <= {1'b1, sreg[9:1]};
        if (bitn == 4'd9) begin
          active <= 1'b0;
          done   <= 1'b1;
        end else bitn <= bitn + 1'b1;
      end else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/abaud_ctrl.sv
module abaud_ctrl
  import abaud_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_MIN  = 16,
  parameter int DIV_MAX  = 41,
  parameter int STEP     = 4,
  parameter int TMO_BITS = 12,
  parameter int TMO_W    = DIV_W + $clog2(TMO_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_done,
  input  logic             byte_match,
  input  logic             rx_busy,
  input  logic             tx_done,
  output logic             tx_start,
  output phase_t           phase,
  output logic [DIV_W-1:0] div,
  output logic             timeout_hit
);
  logic [DIV_W-1:0] fast_lim;
  logic [TMO_W-1:0] idle_cnt;
  logic             sent_one;
  logic             searching;

  assign searching   = (phase == PH_FAST) || (phase == PH_SLOW);
  assign timeout_hit = searching && !rx_busy && !byte_done &&
                       (int'(idle_cnt) >= idle_limit(int'(div), TMO_BITS) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_FAST; div <= DIV_W'(DIV_MIN); fast_lim <= '0;
      idle_cnt <= '0; sent_one <= 1'b0; tx_start <= 1'b0;
    end else begin
      tx_start <= 1'b0;
      if (!searching || rx_busy || byte_done || timeout_hit) idle_cnt <= '0;
      else idle_cnt <= idle_cnt + 1'b1;

      if (timeout_hit) begin
        phase    <= PH_FAST;
        div      <= DIV_W'(DIV_MIN);
        fast_lim <= '0;
      end else begin
        case (phase)
          PH_FAST: if (byte_done) begin
            if (byte_match) begin
              fast_lim <= div;
              div      <= DIV_W'(DIV_MAX);
              phase    <= PH_SLOW;
            end else div <= DIV_W'(div_slower(int'(div), STEP, DIV_MAX));
          end
          PH_SLOW: if (byte_done) begin
            if (byte_match) begin
              div      <= DIV_W'(div_centre(int'(fast_lim), int'(div)));
              phase    <= PH_SEND;
              tx_start <= 1'b1;
              sent_one <= 1'b0;
            end else div <= DIV_W'(div_faster(int'(div), STEP, DIV_MIN));
          end
          PH_SEND: if (tx_done) begin
            if (sent_one) phase <= PH_LOCK;
            else begin
              sent_one <= 1'b1;
              tx_start <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/abaud_slave.sv
module abaud_slave
  import abaud_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_MIN  = 16,
  parameter int DIV_MAX  = 41,
  parameter int STEP     = 4,
  parameter int TMO_BITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  output logic             tx,
  output logic             locked,
  output logic [DIV_W-1:0] rate_div,
  output logic [1:0]       cal_phase
);
  logic       byte_done, frame_ok, rx_busy, byte_match;
  logic [7:0] rx_data;
  logic       tx_start, tx_done, timeout_hit;
  phase_t     phase;

  abaud_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx(rx), .div(rate_div),
    .done(byte_done), .data(rx_data), .frame_ok(frame_ok), .busy(rx_busy)
  );

  // a bad stop bit counts as a mismatch
  assign byte_match = frame_ok && (rx_data == CAL_BYTE);

  abaud_ctrl #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX),
    .STEP(STEP), .TMO_BITS(TMO_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_match(byte_match),
    .rx_busy(rx_busy), .tx_done(tx_done), .tx_start(tx_start),
    .phase(phase), .div(rate_div), .timeout_hit(timeout_hit)
  );

  abaud_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .data(ACK_BYTE),
    .div(rate_div), .tx(tx), .done(tx_done)
  );

  assign cal_phase = phase;
  assign locked    = (phase == PH_LOCK);
endmodule

// File: rtl/abaud_slave_chk.sv
module abaud_slave_chk #(
  parameter int DIV_W   = 8,
  parameter int DIV_MIN = 16,
  parameter int DIV_MAX = 41,
  parameter int STEP    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cal_phase,
  input logic [DIV_W-1:0] rate_div,
  input logic             tx,
  input logic             byte_done,
  input logic             byte_match,
  input logic             timeout_hit
);
  a_r2_step_slower: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_phase == 2'd0 && byte_done && !byte_match) |=>
      (int'(rate_div) == ((int'($past(rate_div)) + STEP > DIV_MAX) ? DIV_MAX : int'($past(rate_div)) + STEP)));

  a_r4_jump_slowest: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_phase == 2'd0 && byte_done && byte_match) |=>
      (cal_phase == 2'd1 && int'(rate_div) == DIV_MAX));

  a_r5_step_faster: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_phase == 2'd1 && byte_done && !byte_match) |=>
      (int'(rate_div) == ((int'($past(rate_div)) - STEP < DIV_MIN) ? DIV_MIN : int'($past(rate_div)) - STEP)));

  a_r5_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rate_div) >= DIV_MIN && int'(rate_div) <= DIV_MAX));

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> (cal_phase == 2'd0 && int'(rate_div) == DIV_MIN));

  a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_phase == 2'd3) |=> (cal_phase == 2'd3 && $stable(rate_div)));

  a_r10_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_phase != 2'd2) |-> tx);
endmodule

bind abaud_slave abaud_slave_chk #(
  .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_phase(cal_phase), .rate_div(rate_div),
  .tx(tx), .byte_done(byte_done), .byte_match(byte_match), .timeout_hit(timeout_hit)
);

// File: tb/abaud_slave_tb.sv
module abaud_slave_tb;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic tx, locked;
  logic [DIV_W-1:0] rate_div;
  logic [1:0] cal_phase;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  abaud_slave #(.DIV_W(DIV_W), .DIV_MIN(16), .DIV_MAX(41), .STEP(4), .TMO_BITS(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .tx(tx), .locked(locked),
    .rate_div(rate_div), .cal_phase(cal_phase)
  );

  typedef struct packed {
    logic [7:0] data;
    logic       stop;
    logic [7:0] div;
    logic [1:0] ph;
  } vec_t;

  // byte sent at the expected divisor, stop-bit level, divisor and phase afterwards
  localparam vec_t VEC [5] = '{
    '{8'h33, 1'b1, 8'd20, 2'd0},   // R2 mismatch
    '{8'hAA, 1'b0, 8'd24, 2'd0},   // R3 framing error
    '{8'hAA, 1'b1, 8'd41, 2'd1},   // R4 fast-side limit 24
    '{8'h55, 1'b1, 8'd37, 2'd1},   // R5 mismatch
    '{8'hAB, 1'b1, 8'd33, 2'd1}    // R5 mismatch
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_frame(logic [7:0] d, logic stop, int div);
    @(negedge clk);
    rx = 1'b0;
    repeat (div) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (div) @(negedge clk);
    end
    rx = stop;
    repeat (div) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic send_byte(logic [7:0] d, logic stop, int div);
    send_frame(d, stop, div);
    repeat (2 * div) @(negedge clk);
  endtask

  task automatic read_tx(int div, output logic [7:0] d, output logic ok);
    int guard = 0;
    ok = 1'b1;
    while (tx !== 1'b0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 2000) ok = 1'b0;
    repeat (div / 2) @(negedge clk);
    if (tx !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (div) @(negedge clk);
      d[i] = tx;
    end
    repeat (div) @(negedge clk);
    if (tx !== 1'b1) ok = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // final 0xAA of a search, then both announce frames at the centred divisor
  task automatic finish_cal(int slow_div, int centre);
    logic [7:0] b0, b1;
    logic ok0, ok1;
    fork
      begin
        send_frame(8'hAA, 1'b1, slow_div);
        check("R6 centred divisor", int'(rate_div), centre);
        check("R6 announce phase", int'(cal_phase), 2);
      end
      begin
        read_tx(centre, b0, ok0);
        read_tx(centre, b1, ok1);
      end
    join
    check("R7 frame 1 data", int'(b0), 8'h55);
    check("R7 frame 1 framing", int'(ok0), 1);
    check("R7 frame 2 data", int'(b1), 8'h55);
    check("R7 frame 2 framing", int'(ok1), 1);
    repeat (centre) @(negedge clk);
    check("R7 locked", int'(locked), 1);
    check("R7 locked phase", int'(cal_phase), 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cur;
    int tx_low;
    do_reset();
    check("R1 reset phase", int'(cal_phase), 0);
    check("R1 reset divisor", int'(rate_div), 16);
    check("R1 reset tx", int'(tx), 1);
    check("R1 reset locked", int'(locked), 0);

    // vector walk: fast limit 24, slow limit 33, centre floor(57/2)=28
    cur = 16;
    foreach (VEC[i]) begin
      send_byte(VEC[i].data, VEC[i].stop, cur);
      check("R2-R5 vector divisor", int'(rate_div), int'(VEC[i].div));
      check("R2-R5 vector phase", int'(cal_phase), int'(VEC[i].ph));
      check("R10 tx idle in search", int'(tx), 1);
      cur = int'(VEC[i].div);
    end
    finish_cal(cur, 28);

    // R9: a locked slave ignores calibration and other bytes
    tx_low = 0;
    fork
      begin
        send_byte(8'hAA, 1'b1, 28);
        send_byte(8'h12, 1'b1, 28);
      end
      begin
        repeat (40 * 28) begin
          @(negedge clk);
          if (tx == 1'b0) tx_low++;
        end
      end
    join
    check("R9 divisor held", int'(rate_div), 28);
    check("R9 phase held", int'(cal_phase), 3);
    check("R10 tx idle when locked", tx_low, 0);

    // R2 and R5 saturation at both ends
    do_reset();
    cur = 16;
    for (int i = 0; i < 8; i++) begin
      send_byte(8'h00, 1'b1, cur);
      cur = (cur + 4 > 41) ? 41 : cur + 4;
      check("R2 step slower with cap", int'(rate_div), cur);
    end
    send_byte(8'hAA, 1'b1, cur);
    check("R4 upper limit at cap", int'(cal_phase), 1);
    check("R4 jump to slowest", int'(rate_div), 41);
    cur = 41;
    for (int i = 0; i < 8; i++) begin
      send_byte(8'hF0, 1'b1, cur);
      cur = (cur - 4 < 16) ? 16 : cur - 4;
      check("R5 step faster with floor", int'(rate_div), cur);
    end
    finish_cal(16, 28);

    // R8: idle timeout of 12 bit periods during the slow-side search
    do_reset();
    send_byte(8'h00, 1'b1, 16);
    check("R2 before timeout", int'(rate_div), 20);
    send_byte(8'hAA, 1'b1, 20);
    check("R4 before timeout", int'(cal_phase), 1);
    repeat (300) @(negedge clk);
    check("R8 still searching inside window", int'(cal_phase), 1);
    check("R8 divisor inside window", int'(rate_div), 41);
    repeat (200) @(negedge clk);
    check("R8 restart phase", int'(cal_phase), 0);
    check("R8 restart divisor", int'(rate_div), 16);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule